// File: doc/BRIEF.md
# Chainable Periodic Down-Counter Timer

This block is a multi-channel periodic timer. Every channel owns a down-counter. The counter is preset from a programmable start value when the channel is switched on. When it reaches zero it raises a timeout flag and presets itself again from the start value. A channel can also be told to take its count pulses from the expiries of the channel below it. Two 32-bit channels then form one 64-bit interval.

Software reaches the block through a plain word-addressed register port. Writes are synchronous and reads are combinational. A global word holds a disable bit and a freeze bit. The freeze bit stops all counters while the debug-halt input is high. Every channel that has a pending timeout and its interrupt enabled drives one shared interrupt output.

Address map: the global word is at address 0. The words of channel n start at base 4*(n+1):
- base+0: start value
- base+1: current count (read only)
- base+2: control
- base+3: timeout flag

Top module: `chain_timer`

## Requirements
- R1: While running and not halted, a channel's count drops by one on every clock edge. The count reads back at word base+1, and it is 0 after reset.
- R2: Writing the control word (base+2) with bit 0 (run) set, while run was clear, presets the count to the start value held at base+0. Writing run to 0 keeps the count at its value from then on.
- R3: On a counting edge at which the count is 0, the channel presets the count from the start value and sets its timeout flag (bit 0 of base+3). The period is therefore start value + 1 clocks.
- R4: A start value written while the channel runs leaves the current count alone and is first used at the next expiry.
- R5: With control bit 2 (chain) set, channel n with n>0 decrements only on edges at which channel n-1 expires. With chain clear, the channel counts on every clock.
- R6: The interrupt output is high exactly while some channel has both its timeout flag and control bit 1 (interrupt enable) set.
- R7: Global word bit 0 (disable) stops every channel. Global word bit 1 (freeze) stops every channel while the debug-halt input is high. The counts hold, and counting resumes from them when the condition ends.
- R8: Writing 1 to bit 0 of base+3 clears the timeout flag. If an expiry happens on the same edge, the flag stays set.
- R9: Channel 0 has no predecessor, so its chain bit has no effect and it counts on every clock.
- R10: A start value of 0 makes the channel expire on every counting edge, with the count staying at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every counting pulse is one edge |
| rstN | input | 1 | Asynchronous reset, active low |
| regWe | input | 1 | Write strobe for the register port |
| regAddr | input | ADDR_W | Word address for reads and writes |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Combinational read data of the addressed word |
| dbgHalt | input | 1 | Debug halt; stops counting while the freeze bit is set |
| irq | output | 1 | Combined interrupt request of all channels |

## Verification
A wrong count is visible in the current-count word on the very next read. Because the reload is taken from a separately held start value, an error in the preset path shows one period later as a wrong count right after the flag rises. Errors in the chain or halt gating show as a count that moves when it should hold, or holds when it should move, within a single clock. Flag priority faults are exposed by placing a clear write on exactly the expiry edge and by running a start value of 0, where every edge expires.

// File: rtl/ctmr_pkg.sv
package ctmr_pkg;
  // per-channel strobes from the control side to the counting core
  typedef struct packed {
    logic startLoad;  // preset counter from start value
    logic countEn;    // channel may count this cycle
    logic chained;    // count only on predecessor expiry
    logic clrFlag;    // write-one-to-clear of the timeout flag
  } chStrobe_t;
endpackage

// File: rtl/ctmr_ctrl.sv
module ctmr_ctrl
  import ctmr_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  input  logic              dbgHalt,
  input  logic [CNT_W-1:0]  cntVal [NUM_CH],
  input  logic [NUM_CH-1:0] flagVec,
  output logic [CNT_W-1:0]  loadVal [NUM_CH],
  output logic [NUM_CH-1:0] irqEnVec,
  output chStrobe_t         strobe [NUM_CH]
);
  localparam int SEL_W = ADDR_W - 2;
  localparam logic [1:0] F_LOAD = 2'd0;
  localparam logic [1:0] F_CUR  = 2'd1;
  localparam logic [1:0] F_CTRL = 2'd2;
  localparam logic [1:0] F_FLAG = 2'd3;

  logic [SEL_W-1:0] wordSel;
  logic [1:0]       fieldSel;
  logic             disableBit, freezeBit, haltAll;
  logic [NUM_CH-1:0] runBit, chainBit;

  assign wordSel  = regAddr[ADDR_W-1:2];
  assign fieldSel = regAddr[1:0];
  assign haltAll  = disableBit | (freezeBit & dbgHalt);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      disableBit <= 1'b0;
      freezeBit  <= 1'b0;
    end else if (regWe && wordSel == '0 && fieldSel == 2'd0) begin
      disableBit <= regWdata[0];
      freezeBit  <= regWdata[1];
    end
  end

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    logic hitCh;
    assign hitCh = regWe && (wordSel == SEL_W'(n + 1));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        loadVal[n]  <= '0;
        runBit[n]   <= 1'b0;
        irqEnVec[n] <= 1'b0;
        chainBit[n] <= 1'b0;
      end else if (hitCh) begin
        if (fieldSel == F_LOAD) loadVal[n] <= regWdata[CNT_W-1:0];
        if (fieldSel == F_CTRL) begin
          runBit[n]   <= regWdata[0];
          irqEnVec[n] <= regWdata[1];
          chainBit[n] <= regWdata[2];
        end
      end
    end

    assign strobe[n].startLoad = hitCh && fieldSel == F_CTRL && regWdata[0] && !runBit[n];
    assign strobe[n].countEn   = runBit[n] && !haltAll;
    assign strobe[n].chained   = (n != 0) && chainBit[n];  // R9: channel 0 never chained
    assign strobe[n].clrFlag   = hitCh && fieldSel == F_FLAG && regWdata[0];

    // R7: no counting permission while halted
    p_halt_gate_r7: assert property (@(posedge clk) disable iff (!rstN)
      (disableBit || (freezeBit && dbgHalt)) |-> !strobe[n].countEn);
  end

  always_comb begin
    regRdata = '0;
    if (wordSel == '0) begin
      if (fieldSel == 2'd0) regRdata = {30'd0, freezeBit, disableBit};
    end else begin
      for (int n = 0; n < NUM_CH; n++) begin
        if (wordSel == SEL_W'(n + 1)) begin
          case (fieldSel)
            F_LOAD:  regRdata = 32'(loadVal[n]);
            F_CUR:   regRdata = 32'(cntVal[n]);
            F_CTRL:  regRdata = {29'd0, chainBit[n], irqEnVec[n], runBit[n]};
            default: regRdata = {31'd0, flagVec[n]};
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/ctmr_core.sv
module ctmr_core
  import ctmr_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  chStrobe_t         strobe [NUM_CH],
  input  logic [CNT_W-1:0]  loadVal [NUM_CH],
  output logic [CNT_W-1:0]  cntVal [NUM_CH],
  output logic [NUM_CH-1:0] flagVec
);
  logic [NUM_CH-1:0] stepVec, expireVec;

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    if (n == 0) begin : g_head
      assign stepVec[n] = strobe[n].countEn;
    end else begin : g_link
      // R5: a chained channel counts only on the predecessor's expiry
      assign stepVec[n] = strobe[n].countEn && (!strobe[n].chained || expireVec[n-1]);
    end
    assign expireVec[n] = stepVec[n] && (cntVal[n] == '0);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                   cntVal[n] <= '0;
      else if (strobe[n].startLoad) cntVal[n] <= loadVal[n];
      else if (expireVec[n])        cntVal[n] <= loadVal[n];
      else if (stepVec[n])          cntVal[n] <= cntVal[n] - 1'b1;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                  flagVec[n] <= 1'b0;
      else if (expireVec[n])      flagVec[n] <= 1'b1;  // R8: expiry beats clear
      else if (strobe[n].clrFlag) flagVec[n] <= 1'b0;
    end

    p_decrement_r1: assert property (@(posedge clk) disable iff (!rstN)
      (stepVec[n] && cntVal[n] != '0 && !strobe[n].startLoad)
        |=> cntVal[n] == $past(cntVal[n]) - 1'b1);
    p_start_r2: assert property (@(posedge clk) disable iff (!rstN)
      strobe[n].startLoad |=> cntVal[n] == $past(loadVal[n]));
    p_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
      (!strobe[n].countEn && !strobe[n].startLoad) |=> $stable(cntVal[n]));
    p_reload_r3: assert property (@(posedge clk) disable iff (!rstN)
      (expireVec[n] && !strobe[n].startLoad)
        |=> flagVec[n] && cntVal[n] == $past(loadVal[n]));
    p_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
      (strobe[n].clrFlag && !expireVec[n]) |=> !flagVec[n]);
  end
endmodule

// File: rtl/chain_timer.sv
module chain_timer
  import ctmr_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int CNT_W  = 32,
  parameter int ADDR_W = $clog2(4 * (NUM_CH + 1))
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  input  logic              dbgHalt,
  output logic              irq
);
  chStrobe_t         strobe [NUM_CH];
  logic [CNT_W-1:0]  loadVal [NUM_CH];
  logic [CNT_W-1:0]  cntVal [NUM_CH];
  logic [NUM_CH-1:0] flagVec, irqEnVec;

  ctmr_ctrl #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .dbgHalt(dbgHalt),
    .cntVal(cntVal), .flagVec(flagVec), .loadVal(loadVal),
    .irqEnVec(irqEnVec), .strobe(strobe)
  );

  ctmr_core #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_core (
    .clk(clk), .rstN(rstN), .strobe(strobe), .loadVal(loadVal),
    .cntVal(cntVal), .flagVec(flagVec)
  );

  assign irq = |(flagVec & irqEnVec);  // R6

  p_irq_source_r6: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (flagVec != '0));
endmodule

// File: tb/sim_chain_timer.sv
module sim_chain_timer;
  localparam int ADDR_W = 4;
  logic clk = 1'b0, rstN = 1'b0, regWe = 1'b0, dbgHalt = 1'b0;
  logic [ADDR_W-1:0] regAddr = '0;
  logic [31:0] regWdata = '0, regRdata;
  logic irq;
  int total = 0, bad = 0;
  bit done = 0;

  chain_timer u0 (.clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .dbgHalt(dbgHalt), .irq(irq));

  always #10 clk = ~clk;  // 50 MHz

  function automatic logic [3:0] adr(int ch, int f);
    return 4'(4 * (ch + 1) + f);
  endfunction

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, got, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(posedge clk); @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    regAddr = a; #1; d = regRdata;
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(adr(0, 1), v); chk("R1 reset count", v, 0);
    rd(adr(0, 3), v); chk("R3 reset flag", v, 0);
    chk("R6 reset irq", irq, 0);
  endtask

  task automatic t_basic;
    logic [31:0] v;
    wr(adr(0, 0), 5);
    wr(adr(0, 2), 1);
    rd(adr(0, 1), v); chk("R2 start preset", v, 5);
    tick(2); rd(adr(0, 1), v); chk("R1 decrement", v, 3);
    tick(3); rd(adr(0, 1), v); chk("R1 reach zero", v, 0);
    rd(adr(0, 3), v); chk("R3 no flag before expiry", v, 0);
    tick(1); rd(adr(0, 1), v); chk("R3 reload", v, 5);
    rd(adr(0, 3), v); chk("R3 flag set", v, 1);
    chk("R6 no irq without enable", irq, 0);
    wr(adr(0, 2), 3);
    chk("R6 irq raised", irq, 1);
    rd(adr(0, 1), v); chk("R2 ctrl rewrite no preset", v, 4);
    wr(adr(0, 3), 1);
    rd(adr(0, 3), v); chk("R8 flag cleared", v, 0);
    chk("R6 irq dropped", irq, 0);
  endtask

  task automatic t_stop;
    logic [31:0] a, b;
    wr(adr(0, 2), 0);
    rd(adr(0, 1), a); tick(5); rd(adr(0, 1), b);
    chk("R2 stopped holds", b, a);
    wr(adr(0, 2), 1);
    rd(adr(0, 1), b); chk("R2 restart preset", b, 5);
  endtask

  task automatic t_newload;
    logic [31:0] v;
    wr(adr(0, 0), 2);
    rd(adr(0, 1), v); chk("R4 count undisturbed", v, 4);
    tick(4); rd(adr(0, 1), v); chk("R4 old run to zero", v, 0);
    tick(1); rd(adr(0, 1), v); chk("R4 new value at reload", v, 2);
    wr(adr(0, 3), 1);
    tick(1);
    wr(adr(0, 3), 1);  // clear lands on expiry edge
    rd(adr(0, 3), v); chk("R8 expiry beats clear", v, 1);
    rd(adr(0, 1), v); chk("R3 period load+1", v, 2);
  endtask

  task automatic t_zero;
    logic [31:0] v;
    wr(adr(0, 2), 0);
    wr(adr(0, 3), 1);
    rd(adr(0, 3), v); chk("R8 clear while stopped", v, 0);
    wr(adr(0, 0), 0);
    wr(adr(0, 2), 1);
    rd(adr(0, 3), v); chk("R10 no flag at start", v, 0);
    tick(1);
    rd(adr(0, 3), v); chk("R10 expiry each clock", v, 1);
    rd(adr(0, 1), v); chk("R10 count stays zero", v, 0);
    wr(adr(0, 3), 1);
    rd(adr(0, 3), v); chk("R10 R8 clear loses", v, 1);
    wr(adr(0, 2), 0);
  endtask

  task automatic t_halt;
    logic [31:0] a, b;
    wr(adr(0, 0), 9);
    wr(adr(0, 2), 1);
    wr(0, 1);
    rd(adr(0, 1), a); tick(4); rd(adr(0, 1), b);
    chk("R7 disable holds", b, a);
    wr(0, 0);
    rd(adr(0, 1), a); tick(2); rd(adr(0, 1), b);
    chk("R7 resume after disable", b, a - 2);
    wr(0, 2);
    rd(adr(0, 1), a); tick(3); rd(adr(0, 1), b);
    chk("R7 freeze without debug runs", b, a - 3);
    dbgHalt = 1'b1;
    rd(adr(0, 1), a); tick(3); rd(adr(0, 1), b);
    chk("R7 freeze with debug holds", b, a);
    dbgHalt = 1'b0;
    tick(1); rd(adr(0, 1), b);
    chk("R7 freeze released", b, a - 1);
    wr(0, 0);
    wr(adr(0, 2), 0);
  endtask

  task automatic t_chain;
    logic [31:0] v;
    wr(adr(0, 0), 2);
    wr(adr(1, 0), 1);
    wr(adr(1, 3), 1);
    wr(adr(1, 2), 5);
    tick(3); rd(adr(1, 1), v); chk("R5 chained waits", v, 1);
    wr(adr(0, 2), 1);
    tick(2); rd(adr(1, 1), v); chk("R5 no step before underflow", v, 1);
    tick(1); rd(adr(1, 1), v); chk("R5 step on underflow", v, 0);
    rd(adr(1, 3), v); chk("R5 no flag yet", v, 0);
    tick(3); rd(adr(1, 1), v); chk("R5 chained reload", v, 1);
    rd(adr(1, 3), v); chk("R5 chained flag", v, 1);
    wr(adr(0, 2), 0);
    wr(adr(1, 2), 0);
    wr(adr(1, 0), 7);
    wr(adr(1, 2), 1);
    tick(3); rd(adr(1, 1), v); chk("R5 unchained own clock", v, 4);
    wr(adr(1, 2), 0);
  endtask

  task automatic t_head;
    logic [31:0] v;
    wr(adr(0, 0), 3);
    wr(adr(0, 2), 5);
    tick(2); rd(adr(0, 1), v); chk("R9 channel 0 chain ignored", v, 1);
    wr(adr(0, 2), 0);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    tick(3);
    rstN = 1'b1;
    tick(1);
    t_reset();
    t_basic();
    t_stop();
    t_newload();
    t_zero();
    t_halt();
    t_chain();
    t_head();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule